// File: doc/BRIEF.md
# Periodic Conversion Trigger Controller

This block decides when one output channel starts a conversion. It produces a single-cycle `conv_pulse` whenever one of its trigger sources fires. There are three sources: a software start strobe, a trigger line from outside the chip, and an internal interval timer. A 2-bit mode field chooses which sources count. The modes are: off; one conversion per request; start then repeat on the timer; and outside triggers only.

The interval timer has two stages, and both count a slow base tick. The first stage divides the tick by an 8-bit prescale value. The second stage divides that result by a 16-bit interval value, so the trigger period is the product of the two values in base ticks. Out-of-range values are raised to the legal minimum before use. A direction input can make the channel the master of a shared trigger line. In that case each timer expiry is driven onto the line, the output enable is asserted, and the channel ignores the line as an input.

Top module: `conv_trigger_ctrl`

## Requirements
- R1: With mode = 00, no input of any kind produces a `conv_pulse`.
- R2: With mode = 01, each sampled `sw_start` and each accepted outside-trigger edge produces exactly one `conv_pulse`, and the interval timer never produces one.
- R3: With mode = 10, a start request produces a `conv_pulse` at once and starts the timer. If the request is sampled at clock edge k, a further pulse follows after edges k+1+P, k+1+2P, and so on, where P = prescale × interval counted in base ticks.
- R4: With mode = 11, only outside-trigger edges produce `conv_pulse`. Software starts and timer expiries are ignored.
- R5: `ext_trig_oe` equals `trig_dir` one cycle later. While `trig_dir` = 1, each timer-driven pulse also appears on `ext_trig_out` in the same cycle, software pulses do not appear there, and `ext_trig_in` is ignored. While `trig_dir` = 0, `ext_trig_out` stays 0.
- R6: A prescale value below 53 acts as 53, and an interval value of 0 acts as 1. The period therefore never falls below 53 base ticks.
- R7: A new start request in mode 10, or any change of mode, reloads both timer stages. A change of mode away from 10 also stops the repeating pulses.
- R8: Reset clears `conv_pulse`, `ext_trig_out`, `ext_trig_oe` and both stored timer values to 0.
- R9: `ext_trig_in` passes through two synchronizing flops and is edge-detected. A level that goes high before clock edge c gives one `conv_pulse` in the cycle after edge c+2. Holding the level high gives no further pulses, and a falling edge gives none.
- R10: A write strobe stores its data value, and `psc_rdata` / `tmr_rdata` return the stored, unclamped values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Trigger mode: 00 off, 01 single, 10 continuous, 11 outside only |
| trig_dir | input | 1 | 1 = drive the shared trigger line, 0 = listen to it |
| sw_start | input | 1 | One-cycle software start strobe |
| ext_trig_in | input | 1 | Asynchronous outside trigger level |
| base_tick | input | 1 | Base tick enable for the prescaler (8 MHz rate in a system) |
| psc_wr | input | 1 | Write strobe for the prescale value |
| psc_wdata | input | 8 | Prescale write data |
| tmr_wr | input | 1 | Write strobe for the interval value |
| tmr_wdata | input | 16 | Interval write data |
| psc_rdata | output | 8 | Stored prescale value |
| tmr_rdata | output | 16 | Stored interval value |
| conv_pulse | output | 1 | One-cycle conversion request |
| ext_trig_out | output | 1 | Timer expiry driven onto the shared line |
| ext_trig_oe | output | 1 | Output enable for the shared line |

## Verification
A software start is due in the cycle after the edge that samples it, and an outside-trigger edge is due two cycles later than that. With the base tick held high, timer pulses are due 1+P cycles after the start and then every P cycles. The bench keeps a cycle counter stepped on each rising edge. Every stimulus task pushes the exact cycle number at which a pulse must appear. A monitor at each falling edge pops that number and compares it, and it reports any pulse that comes early, comes late, or was not expected. Stretches where nothing should happen are checked by confirming that the count of seen pulses did not change.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_CONT   = 2'b10,
    MODE_EXT    = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b0;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R9: an edge is reported for a single cycle only
  p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int PSC_W   = 8,
  parameter int TMR_W   = 16,
  parameter int PSC_MIN = 53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             enable,
  input  logic             base_tick,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [TMR_W-1:0] tmr_val,
  output logic             tick
);
  localparam logic [PSC_W-1:0] PSC_FLOOR = PSC_W'(PSC_MIN);
  localparam logic [TMR_W-1:0] TMR_FLOOR = TMR_W'(1);

  logic [PSC_W-1:0] psc_lim, psc_cnt;
  logic [TMR_W-1:0] tmr_lim, tmr_cnt;

  assign psc_lim = (psc_val < PSC_FLOOR) ? PSC_FLOOR : psc_val;
  assign tmr_lim = (tmr_val == '0) ? TMR_FLOOR : tmr_val;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      psc_cnt <= '0;
      tmr_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (enable && base_tick) begin
        if (psc_cnt == psc_lim - 1'b1) begin
          psc_cnt <= '0;
          if (tmr_cnt == tmr_lim - 1'b1) begin
            tmr_cnt <= '0;
            tick    <= 1'b1;
          end else begin
            tmr_cnt <= tmr_cnt + 1'b1;
          end
        end else begin
          psc_cnt <= psc_cnt + 1'b1;
        end
      end
    end
  end

  // R6: period is at least PSC_MIN base ticks, so expiries never touch
  p_min_gap_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R7: a reload leaves the timer without an expiry in the next cycle
  p_reload_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

// File: rtl/conv_trigger_ctrl.sv
module conv_trigger_ctrl
  import trig_pkg::*;
#(
  parameter int PSC_W       = 8,
  parameter int TMR_W       = 16,
  parameter int PSC_MIN     = 53,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             trig_dir,
  input  logic             sw_start,
  input  logic             ext_trig_in,
  input  logic             base_tick,
  input  logic             psc_wr,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  output logic [PSC_W-1:0] psc_rdata,
  output logic [TMR_W-1:0] tmr_rdata,
  output logic             conv_pulse,
  output logic             ext_trig_out,
  output logic             ext_trig_oe
);
  trig_mode_e       mode_e, mode_q;
  logic [PSC_W-1:0] psc_q;
  logic [TMR_W-1:0] tmr_q;
  logic             running_q;
  logic             ext_rise, tick;
  logic             ext_ok, start_req, mode_chg, tick_ok;
  logic             fire, restart, run_d;

  assign mode_e = trig_mode_e'(mode);

  // Stored timer values
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= '0;
      tmr_q <= '0;
    end else begin
      if (psc_wr) psc_q <= psc_wdata;
      if (tmr_wr) tmr_q <= tmr_wdata;
    end
  end
  assign psc_rdata = psc_q;
  assign tmr_rdata = tmr_q;

  trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_trig_in),
    .rise     (ext_rise)
  );

  interval_timer #(.PSC_W(PSC_W), .TMR_W(TMR_W), .PSC_MIN(PSC_MIN)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .enable    (running_q),
    .base_tick (base_tick),
    .psc_val   (psc_q),
    .tmr_val   (tmr_q),
    .tick      (tick)
  );

  // Source selection
  assign ext_ok    = ext_rise && !trig_dir;
  assign start_req = sw_start || ext_ok;
  assign mode_chg  = (mode_e != mode_q);
  assign tick_ok   = tick && running_q && !mode_chg;
  assign restart   = mode_chg || (mode_e == MODE_CONT && start_req);
  assign run_d     = (mode_e == MODE_CONT) &&
                     (start_req || (running_q && !mode_chg));

  always_comb begin
    case (mode_e)
      MODE_SINGLE: fire = start_req;
      MODE_CONT:   fire = start_req || tick_ok;
      MODE_EXT:    fire = ext_ok;
      default:     fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_OFF;
      running_q    <= 1'b0;
      conv_pulse   <= 1'b0;
      ext_trig_out <= 1'b0;
      ext_trig_oe  <= 1'b0;
    end else begin
      mode_q       <= mode_e;
      running_q    <= run_d;
      conv_pulse   <= fire;
      ext_trig_out <= trig_dir && tick_ok;
      ext_trig_oe  <= trig_dir;
    end
  end

  // R1: disabled mode never requests a conversion
  p_off_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_OFF) |=> !conv_pulse);
  // R2: single mode fires only on a request
  p_single_req_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_SINGLE && !sw_start && !ext_rise) |=> !conv_pulse);
  // R3: continuous mode is silent until started
  p_cont_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_CONT && !running_q && !sw_start && !ext_rise) |=> !conv_pulse);
  // R4: outside-only mode fires only on a synchronized edge
  p_ext_only_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_EXT && !ext_rise) |=> !conv_pulse);
  // R5: the line is driven only while its enable is on
  p_pin_enable_r5: assert property (@(posedge clk) disable iff (rst)
    !ext_trig_oe |-> !ext_trig_out);
  // R5: a driven expiry is always a conversion in the same cycle
  p_pin_conv_r5: assert property (@(posedge clk) disable iff (rst)
    ext_trig_out |-> conv_pulse);
endmodule

// File: tb/conv_trigger_ctrl_tb.sv
module conv_trigger_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        trig_dir = 1'b0;
  logic        sw_start = 1'b0;
  logic        ext_trig_in = 1'b0;
  logic        base_tick = 1'b1;
  logic        psc_wr = 1'b0;
  logic [7:0]  psc_wdata = '0;
  logic        tmr_wr = 1'b0;
  logic [15:0] tmr_wdata = '0;
  logic [7:0]  psc_rdata;
  logic [15:0] tmr_rdata;
  logic        conv_pulse, ext_trig_out, ext_trig_oe;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int seen = 0;
  string cur_req = "R8";
  int expq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_trigger_ctrl u_dut (
    .clk(clk), .rst(rst), .mode(mode), .trig_dir(trig_dir),
    .sw_start(sw_start), .ext_trig_in(ext_trig_in), .base_tick(base_tick),
    .psc_wr(psc_wr), .psc_wdata(psc_wdata), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .psc_rdata(psc_rdata), .tmr_rdata(tmr_rdata), .conv_pulse(conv_pulse),
    .ext_trig_out(ext_trig_out), .ext_trig_oe(ext_trig_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  // Monitor: pops the expected pulse cycles
  always @(negedge clk) begin
    if (!rst) begin
      if (expq.size() > 0 && expq[0] < cyc) begin
        check(1'b0, cur_req, -1, expq[0]);
        void'(expq.pop_front());
      end
      if (conv_pulse) begin
        seen++;
        if (expq.size() > 0 && expq[0] == cyc) begin
          check(1'b1, cur_req, cyc, cyc);
          void'(expq.pop_front());
        end else begin
          check(1'b0, cur_req, cyc, (expq.size() > 0) ? expq[0] : -1);
        end
      end
    end
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
    @(negedge clk);
  endtask

  task automatic wr_regs(input logic [7:0] p, input logic [15:0] t);
    @(negedge clk); psc_wr = 1'b1; psc_wdata = p; tmr_wr = 1'b1; tmr_wdata = t;
    @(negedge clk); psc_wr = 1'b0; tmr_wr = 1'b0;
  endtask

  task automatic sw_pulse(input bit expect_it, output int c);
    @(negedge clk); sw_start = 1'b1; c = cyc + 1;
    if (expect_it) expq.push_back(c);
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic ext_edge(input bit expect_it, output int c);
    @(negedge clk); ext_trig_in = 1'b1; c = cyc + 1;
    if (expect_it) expq.push_back(c + 2);
    repeat (6) @(negedge clk);
    ext_trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int c, c2, s0;
    repeat (4) @(negedge clk);
    // R8: reset state
    check(conv_pulse == 1'b0, "R8", conv_pulse, 0);
    check(ext_trig_out == 1'b0, "R8", ext_trig_out, 0);
    check(ext_trig_oe == 1'b0, "R8", ext_trig_oe, 0);
    check(psc_rdata == 8'd0, "R8", psc_rdata, 0);
    check(tmr_rdata == 16'd0, "R8", tmr_rdata, 0);
    rst = 1'b0;

    // R1: disabled mode
    cur_req = "R1"; s0 = seen;
    sw_pulse(1'b0, c); ext_edge(1'b0, c);
    repeat (20) @(negedge clk);
    check(seen == s0, "R1", seen - s0, 0);

    // R2 and R9: single mode, timer ignored
    cur_req = "R2"; set_mode(2'b01); s0 = seen;
    sw_pulse(1'b1, c);
    cur_req = "R9"; ext_edge(1'b1, c);
    cur_req = "R2"; repeat (200) @(negedge clk);
    check(seen == s0 + 2, "R2", seen - s0, 2);

    // R6 and R3: clamped values give a 53-cycle period
    cur_req = "R6"; set_mode(2'b00); wr_regs(8'd10, 16'd0); set_mode(2'b10); s0 = seen;
    sw_pulse(1'b1, c);
    expq.push_back(c + 54); expq.push_back(c + 107);
    wait_to(c + 54);
    check(ext_trig_out == 1'b0, "R5", ext_trig_out, 0);
    wait_to(c + 130);
    mode = 2'b00;
    repeat (200) @(negedge clk);
    check(seen == s0 + 3, "R7", seen - s0, 3);

    // R3 and R10: programmed period started by outside edge
    cur_req = "R3"; wr_regs(8'd60, 16'd2);
    check(psc_rdata == 8'd60, "R10", psc_rdata, 60);
    check(tmr_rdata == 16'd2, "R10", tmr_rdata, 2);
    set_mode(2'b10); s0 = seen;
    ext_edge(1'b1, c);
    expq.push_back(c + 2 + 121); expq.push_back(c + 2 + 241);
    wait_to(c + 2 + 260);
    mode = 2'b00;
    repeat (300) @(negedge clk);
    check(seen == s0 + 3, "R3", seen - s0, 3);

    // R4: outside-only mode
    cur_req = "R4"; set_mode(2'b11); s0 = seen;
    sw_pulse(1'b0, c);
    ext_edge(1'b1, c);
    repeat (200) @(negedge clk);
    check(seen == s0 + 1, "R4", seen - s0, 1);

    // R5: master direction
    cur_req = "R5"; set_mode(2'b01);
    @(negedge clk); trig_dir = 1'b1;
    @(negedge clk);
    check(ext_trig_oe == 1'b1, "R5", ext_trig_oe, 1);
    s0 = seen;
    ext_edge(1'b0, c);
    repeat (10) @(negedge clk);
    check(seen == s0, "R5", seen - s0, 0);
    wr_regs(8'd0, 16'd0); set_mode(2'b10);
    sw_pulse(1'b1, c);
    check(ext_trig_out == 1'b0, "R5", ext_trig_out, 0);
    expq.push_back(c + 54);
    wait_to(c + 54);
    check(ext_trig_out == 1'b1, "R5", ext_trig_out, 1);
    @(negedge clk);
    check(ext_trig_out == 1'b0, "R5", ext_trig_out, 0);
    wait_to(c + 80);
    mode = 2'b00; trig_dir = 1'b0;
    repeat (3) @(negedge clk);
    check(ext_trig_oe == 1'b0, "R5", ext_trig_oe, 0);

    // R7: a second start reloads the timer
    cur_req = "R7"; set_mode(2'b10); s0 = seen;
    sw_pulse(1'b1, c);
    wait_to(c + 20);
    sw_pulse(1'b1, c2);
    expq.push_back(c2 + 54);
    wait_to(c2 + 80);
    mode = 2'b00;
    repeat (100) @(negedge clk);
    check(seen == s0 + 3, "R7", seen - s0, 3);

    // R8: reset clears stored values
    wr_regs(8'd77, 16'd900);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(psc_rdata == 8'd0, "R8", psc_rdata, 0);
    check(tmr_rdata == 16'd0, "R8", tmr_rdata, 0);
    check(expq.size() == 0, "R3", expq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected 0 (run did not end)", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule